// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block turns single bus actions into correctly timed waveforms on the two I2C wires for a bus master. A controller above it issues one action at a time: START, a one-bit write, a one-bit read, or STOP. A START issued while the bus is already owned becomes a repeated START. Each action is offered on a valid/ready port. The block pulses `done_o` once when the action is complete, and a read returns the bit it sampled together with that pulse.

All timing comes from one time unit U = 1 + max(TPR, 2) system clocks, where TPR is a programmable period value. An SCL low phase lasts 12U clocks and an SCL high phase lasts 8U clocks. New data goes onto SDA 6U+1 clocks after SCL falls, which is near the middle of the low phase. Both wires are open-drain: the block only drives a pull-low enable for each wire, and a released wire reads high.

Top module: `i2c_bit_timer`

## Requirements
- R1: After reset, both pull-low enables are 0, `cmd_ready_o` is 1 and `done_o` is 0.
- R2: A command is taken when `cmd_valid_i` and `cmd_ready_o` are both high. `cmd_ready_o` then stays low until the cycle of `done_o`. `done_o` is a one-cycle pulse, given exactly once per command, and `cmd_ready_o` is high in that cycle.
- R3: START (op 0) on a free bus sets the SDA pull in cycle 1 after acceptance. It sets the SCL pull and `done_o` in cycle 12U+1, and the bus then counts as owned.
- R4: WRITE (op 1) on an owned bus sets SDA in cycle 6U+1 after acceptance: pulled when `cmd_wbit_i` is 0, released when it is 1. SCL is released in cycle 12U+1, and SCL is pulled again with `done_o` in cycle 20U+1. SCL and SDA never change in the same cycle.
- R5: READ (op 2) on an owned bus releases SDA in cycle 6U+1 and has the same SCL timing as WRITE. `rbit_o` returns the SDA level from the last SCL-high cycle (cycle 20U) and is valid with `done_o`. `rbit_o` does not change at any other time.
- R6: STOP (op 3) on an owned bus pulls SDA in cycle 6U+1 and releases SCL in cycle 12U+1. It releases SDA with `done_o` in cycle 20U+1, and the bus is free again.
- R7: START on an owned bus (repeated START) releases SDA in cycle 6U+1 and releases SCL in cycle 12U+1. It pulls SDA in cycle 24U+1, and pulls SCL with `done_o` in cycle 36U+1.
- R8: U is 1 + TPR for TPR of 2 or more. Any TPR below 2 is treated as 2.
- R9: `tpr_i` is sampled only when a START is accepted on a free bus. Changes at any other time have no effect on the timing.
- R10: WRITE, READ or STOP on a free bus gives `done_o` in cycle 1 after acceptance and leaves both wires unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tpr_i | input | TPR_W | Timer period value |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block can accept a command |
| cmd_op_i | input | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_wbit_i | input | 1 | Bit to send for WRITE |
| sda_i | input | 1 | Sampled SDA wire level |
| scl_pull_o | output | 1 | Pull SCL low when 1 |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| done_o | output | 1 | One-cycle completion strobe |
| rbit_o | output | 1 | Bit returned by READ |

## Verification
A phase counter or phase register that goes wrong moves a wire edge by at least one cycle. The per-cycle comparison catches this at the first misplaced edge, which is at most 12U clocks into the command. A wrong bus-owned flag turns a START into the other START form, or turns a STOP into an immediate completion. Either shows up in cycle 1 or at cycle 6U+1 of the next command. A wrongly latched period shows up as shifted edges on the first bit after the START that latched it.

// File: rtl/i2c_bt_pkg.sv
package i2c_bt_pkg;
   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_WRITE = 2'd1,
      OP_READ  = 2'd2,
      OP_STOP  = 2'd3
   } bt_op_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2,
      PH_HOLD = 2'd3
   } bt_phase_e;
endpackage

// File: rtl/i2c_bt_tpr_scale.sv
module i2c_bt_tpr_scale #(
   parameter int TPR_W   = 8,
   parameter int MIN_TPR = 2,
   parameter bit CLAMP   = 1'b1,
   parameter int LEN_W   = TPR_W + 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [TPR_W-1:0] tpr_i,
   output logic [LEN_W-1:0] len6_o,
   output logic [LEN_W-1:0] len8_o,
   output logic [LEN_W-1:0] len12_o
);
   localparam logic [TPR_W-1:0] MIN_V = TPR_W'(MIN_TPR);

   if (MIN_TPR < 1 || MIN_TPR >= (1 << TPR_W)) begin : g_bad_min
      $error("MIN_TPR out of range for TPR_W");
   end
   if (LEN_W < TPR_W + 5) begin : g_bad_len
      $error("LEN_W too narrow for 12*(1+TPR)");
   end

   logic [TPR_W-1:0] tpr_q;
   logic [TPR_W-1:0] tpr_eff;
   logic             take;

   if (CLAMP) begin : g_clamp
      assign tpr_eff = (tpr_i < MIN_V) ? MIN_V : tpr_i;
      assign take    = load_i;
   end else begin : g_reject
      assign tpr_eff = tpr_i;
      assign take    = load_i && (tpr_i >= MIN_V);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tpr_q <= MIN_V;
      end else if (take) begin
         tpr_q <= tpr_eff;
      end
   end

   logic [LEN_W-1:0] unit;
   assign unit    = LEN_W'(tpr_q) + LEN_W'(1);
   assign len6_o  = (unit << 2) + (unit << 1);
   assign len8_o  = unit << 3;
   assign len12_o = (unit << 3) + (unit << 2);
endmodule

// File: rtl/i2c_bt_phase_cnt.sv
module i2c_bt_phase_cnt #(
   parameter int W = 13
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   output logic [W-1:0] cnt_o
);
   if (W < 2) begin : g_bad_w
      $error("phase counter width too small");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_o <= '0;
      end else if (clr_i) begin
         cnt_o <= '0;
      end else begin
         cnt_o <= cnt_o + W'(1);
      end
   end
endmodule

// File: rtl/i2c_bt_seq.sv
module i2c_bt_seq
   import i2c_bt_pkg::*;
#(
   parameter int W = 13
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         cmd_valid_i,
   input  bt_op_e       cmd_op_i,
   input  logic         cmd_wbit_i,
   input  logic         sda_i,
   input  logic [W-1:0] cnt_i,
   input  logic [W-1:0] len6_i,
   input  logic [W-1:0] len8_i,
   input  logic [W-1:0] len12_i,
   output logic         cnt_clr_o,
   output logic         tpr_load_o,
   output logic         ready_o,
   output logic         scl_pull_o,
   output logic         sda_pull_o,
   output logic         done_o,
   output logic         rbit_o
);
   bt_phase_e phase_q;
   bt_op_e    op_q;
   logic      wbit_q;
   logic      owned_q;
   logic [W-1:0] lim;
   logic      end_hit;
   logic      dv_hit;
   logic      accept;
   logic      dv_level;

   always_comb begin
      unique case (phase_q)
         PH_LOW:  lim = len12_i - W'(1);
         PH_HIGH: lim = (op_q == OP_START) ? (len12_i - W'(1)) : (len8_i - W'(1));
         PH_HOLD: lim = len12_i - W'(1);
         default: lim = '0;
      endcase
   end

   always_comb begin
      unique case (op_q)
         OP_WRITE: dv_level = ~wbit_q;
         OP_STOP:  dv_level = 1'b1;
         default:  dv_level = 1'b0;
      endcase
   end

   assign end_hit    = (phase_q != PH_IDLE) && (cnt_i == lim);
   assign dv_hit     = (phase_q == PH_LOW) && (cnt_i == (len6_i - W'(1)));
   assign ready_o    = (phase_q == PH_IDLE);
   assign accept     = cmd_valid_i && ready_o;
   assign cnt_clr_o  = (phase_q == PH_IDLE) || end_hit;
   assign tpr_load_o = accept && (cmd_op_i == OP_START) && !owned_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q    <= PH_IDLE;
         op_q       <= OP_START;
         wbit_q     <= 1'b0;
         owned_q    <= 1'b0;
         scl_pull_o <= 1'b0;
         sda_pull_o <= 1'b0;
         done_o     <= 1'b0;
         rbit_o     <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  op_q   <= cmd_op_i;
                  wbit_q <= cmd_wbit_i;
                  if (owned_q) begin
                     phase_q <= PH_LOW;
                  end else if (cmd_op_i == OP_START) begin
                     sda_pull_o <= 1'b1;
                     phase_q    <= PH_HOLD;
                  end else begin
                     done_o <= 1'b1;
                  end
               end
            end
            PH_LOW: begin
               if (dv_hit) begin
                  sda_pull_o <= dv_level;
               end
               if (end_hit) begin
                  scl_pull_o <= 1'b0;
                  phase_q    <= PH_HIGH;
               end
            end
            PH_HIGH: begin
               if (end_hit) begin
                  unique case (op_q)
                     OP_START: begin
                        sda_pull_o <= 1'b1;
                        phase_q    <= PH_HOLD;
                     end
                     OP_STOP: begin
                        sda_pull_o <= 1'b0;
                        owned_q    <= 1'b0;
                        done_o     <= 1'b1;
                        phase_q    <= PH_IDLE;
                     end
                     OP_READ: begin
                        rbit_o     <= sda_i;
                        scl_pull_o <= 1'b1;
                        done_o     <= 1'b1;
                        phase_q    <= PH_IDLE;
                     end
                     default: begin
                        scl_pull_o <= 1'b1;
                        done_o     <= 1'b1;
                        phase_q    <= PH_IDLE;
                     end
                  endcase
               end
            end
            PH_HOLD: begin
               if (end_hit) begin
                  scl_pull_o <= 1'b1;
                  owned_q    <= 1'b1;
                  done_o     <= 1'b1;
                  phase_q    <= PH_IDLE;
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/i2c_bit_timer.sv
module i2c_bit_timer
   import i2c_bt_pkg::*;
#(
   parameter int TPR_W   = 8,
   parameter int MIN_TPR = 2,
   parameter bit CLAMP   = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [TPR_W-1:0] tpr_i,
   input  logic             cmd_valid_i,
   output logic             cmd_ready_o,
   input  logic [1:0]       cmd_op_i,
   input  logic             cmd_wbit_i,
   input  logic             sda_i,
   output logic             scl_pull_o,
   output logic             sda_pull_o,
   output logic             done_o,
   output logic             rbit_o
);
   localparam int LEN_W = TPR_W + 5;

   logic [LEN_W-1:0] len6, len8, len12, cnt;
   logic             cnt_clr, tpr_load;

   i2c_bt_tpr_scale #(
      .TPR_W(TPR_W), .MIN_TPR(MIN_TPR), .CLAMP(CLAMP), .LEN_W(LEN_W)
   ) u_scale (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tpr_load), .tpr_i(tpr_i),
      .len6_o(len6), .len8_o(len8), .len12_o(len12)
   );

   i2c_bt_phase_cnt #(.W(LEN_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(cnt_clr), .cnt_o(cnt)
   );

   i2c_bt_seq #(.W(LEN_W)) u_seq (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .cmd_valid_i(cmd_valid_i), .cmd_op_i(bt_op_e'(cmd_op_i)),
      .cmd_wbit_i(cmd_wbit_i), .sda_i(sda_i),
      .cnt_i(cnt), .len6_i(len6), .len8_i(len8), .len12_i(len12),
      .cnt_clr_o(cnt_clr), .tpr_load_o(tpr_load), .ready_o(cmd_ready_o),
      .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o),
      .done_o(done_o), .rbit_o(rbit_o)
   );
endmodule

// File: rtl/i2c_bit_timer_chk.sv
module i2c_bit_timer_chk (
   input logic clk_i,
   input logic rst_ni,
   input logic cmd_valid_i,
   input logic cmd_ready_o,
   input logic scl_pull_o,
   input logic sda_pull_o,
   input logic done_o,
   input logic rbit_o
);
   logic [15:0] hi_cnt, lo_cnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hi_cnt <= '0;
         lo_cnt <= '0;
      end else begin
         hi_cnt <= scl_pull_o ? 16'd0 : ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 16'd1);
         lo_cnt <= !scl_pull_o ? 16'd0 : ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 16'd1);
      end
   end

   // R2
   done_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> cmd_ready_o);

   // R2
   accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_valid_i && cmd_ready_o) |=> (!cmd_ready_o || done_o));

   // R4
   no_joint_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |-> ($stable(scl_pull_o) || $stable(sda_pull_o)));

   // R4
   scl_high_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(scl_pull_o) |-> (hi_cnt >= 16'd24));

   // R4
   scl_low_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(scl_pull_o) |-> (lo_cnt >= 16'd36));

   // R6
   stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(sda_pull_o) && !scl_pull_o) |-> done_o);

   // R5
   rbit_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(rbit_o));
endmodule

bind i2c_bit_timer i2c_bit_timer_chk chk_i (
   .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i),
   .cmd_ready_o(cmd_ready_o), .scl_pull_o(scl_pull_o),
   .sda_pull_o(sda_pull_o), .done_o(done_o), .rbit_o(rbit_o)
);

// File: tb/i2c_bit_timer_tb_top.sv
module i2c_bit_timer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] tpr = 8'd2;
   logic       cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'd0;
   logic       cmd_wbit = 1'b0;
   logic       slave_low = 1'b0;
   logic       cmd_ready, scl_pull, sda_pull, done, rbit, sda_line;

   always #4 clk = ~clk;

   assign sda_line = !(sda_pull || slave_low);

   i2c_bit_timer dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tpr_i(tpr),
      .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
      .cmd_op_i(cmd_op), .cmd_wbit_i(cmd_wbit), .sda_i(sda_line),
      .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
      .done_o(done), .rbit_o(rbit)
   );

   int    n_chk = 0;
   int    n_err = 0;
   int    u_m = 3;
   bit    owned_m = 1'b0;
   bit    m_scl = 1'b0;
   bit    m_sda = 1'b0;
   string extra = "";

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(scl_pull == m_scl && sda_pull == m_sda, "R2 idle lines",
             {scl_pull, sda_pull}, {m_scl, m_sda});
         chk(done == 1'b0 && cmd_ready == 1'b1, "R2 idle handshake",
             {done, cmd_ready}, 2'b01);
      end
   endtask

   task automatic run_cmd(input int op, input bit wb);
      int    len;
      string tag;
      bit    es, ed, exp_rbit;
      @(negedge clk);
      chk(cmd_ready == 1'b1, "R2 ready before command", cmd_ready, 1);
      cmd_valid = 1'b1;
      cmd_op    = 2'(op);
      cmd_wbit  = wb;
      exp_rbit  = !slave_low;
      if (!owned_m && op == 0) begin
         u_m = ((tpr < 8'd2) ? 2 : int'(tpr)) + 1;
         len = 12 * u_m + 1;
         tag = "R3";
      end else if (!owned_m) begin
         len = 1;
         tag = "R10";
      end else if (op == 0) begin
         len = 36 * u_m + 1;
         tag = "R7";
      end else if (op == 1) begin
         len = 20 * u_m + 1;
         tag = "R4";
      end else if (op == 2) begin
         len = 20 * u_m + 1;
         tag = "R5";
      end else begin
         len = 20 * u_m + 1;
         tag = "R6";
      end
      tag = {tag, extra};
      es = m_scl;
      ed = m_sda;
      for (int k = 1; k <= len; k++) begin
         @(negedge clk);
         if (k == 1) cmd_valid = 1'b0;
         es = m_scl;
         ed = m_sda;
         if (len == 1) begin
            es = m_scl;
            ed = m_sda;
         end else if (!owned_m) begin
            ed = 1'b1;
            es = (k == len);
         end else if (op == 1 || op == 2) begin
            es = (k <= 12 * u_m) || (k == len);
            if (k >= 6 * u_m + 1) ed = (op == 1) ? !wb : 1'b0;
         end else if (op == 3) begin
            es = (k <= 12 * u_m);
            if (k >= 6 * u_m + 1) ed = (k < len);
         end else begin
            es = (k <= 12 * u_m) || (k == len);
            if (k >= 24 * u_m + 1) ed = 1'b1;
            else if (k >= 6 * u_m + 1) ed = 1'b0;
         end
         chk(scl_pull == es, {tag, " scl"}, scl_pull, es);
         chk(sda_pull == ed, {tag, " sda"}, sda_pull, ed);
         chk(done == (k == len), {"R2 done ", tag}, done, int'(k == len));
         chk(cmd_ready == (k == len), {"R2 ready ", tag}, cmd_ready, int'(k == len));
         if (k == len && owned_m && op == 2)
            chk(rbit == exp_rbit, {"R5 read bit", extra}, rbit, exp_rbit);
      end
      m_scl = es;
      m_sda = ed;
      if (!owned_m && op == 0) owned_m = 1'b1;
      else if (owned_m && op == 3) owned_m = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(scl_pull == 1'b0 && sda_pull == 1'b0, "R1 lines in reset", {scl_pull, sda_pull}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(scl_pull == 1'b0 && sda_pull == 1'b0, "R1 lines after reset", {scl_pull, sda_pull}, 0);
      chk(cmd_ready == 1'b1 && done == 1'b0, "R1 handshake after reset", {cmd_ready, done}, 2);
      idle(3);

      // R10: bit commands with no START are completed without touching the wires
      run_cmd(1, 1'b0);
      run_cmd(3, 1'b0);
      run_cmd(2, 1'b0);
      idle(2);

      // R3 R4 R5 R7 R6 at the fastest setting
      tpr = 8'd2;
      run_cmd(0, 1'b0);
      run_cmd(1, 1'b1);
      run_cmd(1, 1'b0);
      slave_low = 1'b1;
      run_cmd(2, 1'b0);
      slave_low = 1'b0;
      run_cmd(2, 1'b0);
      run_cmd(0, 1'b0);
      run_cmd(1, 1'b1);
      run_cmd(3, 1'b0);
      idle(4);

      // R9: period change after the START must not alter the bit timing
      tpr = 8'd4;
      run_cmd(0, 1'b0);
      tpr = 8'd9;
      extra = " R9";
      run_cmd(1, 1'b0);
      slave_low = 1'b1;
      run_cmd(2, 1'b0);
      slave_low = 1'b0;
      run_cmd(0, 1'b0);
      run_cmd(3, 1'b0);
      idle(2);

      // R8: a period below the minimum is clamped
      tpr = 8'd0;
      extra = " R8";
      run_cmd(0, 1'b0);
      run_cmd(2, 1'b0);
      run_cmd(3, 1'b0);
      extra = "";
      idle(3);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule